// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits on the transmit side of a network interface, after descriptor fetch and DMA. A frame arrives as one or more segments. Each segment is a 32-bit descriptor status word followed by exactly as many bytes as the descriptor's length field gives. The engine copies the bytes into a local frame buffer. Over a window that opens at a byte offset taken from the first segment and runs to the end of the frame, it keeps a ones-complement running sum. The window does not stop at segment boundaries.

When the last segment of a frame has been loaded and checksum insertion is enabled, the engine writes the complemented 16-bit result into the buffer at a second offset, high byte first. It then streams the whole frame out on a valid/ready byte interface. If transmission is disabled when the frame completes, it drops the frame instead. A strobe marks the end of every segment, and a second strobe, carrying the length, marks each frame that is sent.

Top module: `tx_csum_insert`

## Requirements
- R1: The descriptor is decoded as follows: bit 30 starts a frame, bit 29 ends it, bit 28 enables checksum, bits 27:20 give the stuff offset, bits 19:14 give the sum start offset and bits 12:0 give the segment byte count. Bits 31 and 13 have no effect.
- R2: A frame-start descriptor clears the running sum, resets the frame write position to 0 and captures both offsets. Offset fields on descriptors without the frame-start bit are ignored.
- R3: A byte at frame position p is added to the sum when its segment has checksum enable set and p is at least the start offset. This holds across segment boundaries. The byte is the high half of a 16-bit word when p minus the start offset is even, and the low half otherwise.
- R4: An odd final byte acts as a word with a zero low byte. Carries are folded back into 16 bits before the result is inverted.
- R5: On a frame-end segment with checksum enable set, the inverted sum's high byte overwrites frame position S and its low byte overwrites S+1, where S is the stuff offset. A frame-end segment without checksum enable leaves the frame bytes unchanged.
- R6: The buffer holds BUF_BYTES (2048) bytes. Bytes past the end of the buffer are still consumed but are dropped and not summed, so the frame length saturates at BUF_BYTES.
- R7: tx_en_i is sampled when a frame completes. If it is 1 and the frame is not empty, the frame is streamed out. If it is 0, the frame is discarded: out_valid_o and frame_sent_o stay low.
- R8: seg_done_o pulses for exactly one cycle once per segment, after the segment's last byte or at once for a zero-length segment.
- R9: frame_sent_o pulses for one cycle in the cycle after the last output byte is accepted, and frame_len_o then equals the frame length.
- R10: Frame bytes leave in position order. out_last_o is high only on the final byte. out_data_o and out_last_o hold while out_valid_o is high and out_ready_i is low.
- R11: After reset, desc_ready_o is 1 and in_ready_o, out_valid_o, seg_done_o and frame_sent_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor status word valid |
| desc_i | input | 32 | Descriptor status word |
| desc_ready_o | output | 1 | Engine can take a descriptor |
| in_valid_i | input | 1 | Segment byte valid |
| in_data_i | input | 8 | Segment byte |
| in_ready_o | output | 1 | Engine can take a segment byte |
| tx_en_i | input | 1 | Transmit enable, sampled at frame end |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the frame |
| out_ready_i | input | 1 | Downstream accepts output byte |
| seg_done_o | output | 1 | One-cycle pulse per consumed segment |
| frame_sent_o | output | 1 | One-cycle pulse after a frame is sent |
| frame_len_o | output | 12 | Length of the frame just sent |

## Verification
The bench targets a start offset that falls inside a later segment, where an engine that restarts word alignment or summing at each segment boundary would insert a wrong checksum. It also uses odd-length windows and all-ones data, which expose a missing zero pad or a dropped end-around carry. A non-start descriptor carries conflicting offset fields to catch an engine that recaptures them. A frame larger than the buffer checks that the length saturates and that the overflowed bytes are neither written nor summed. Discarded frames, zero-length segments and random backpressure probe the strobes and the hold behaviour of the output.

// File: rtl/tcsi_pkg.sv
package tcsi_pkg;
  localparam int unsigned SUM_W = 32;

  typedef struct packed {
    logic       own;
    logic       sop;
    logic       eop;
    logic       csum_en;
    logic [7:0] stuff_ofs;
    logic [5:0] start_ofs;
    logic       rsvd;
    logic [12:0] seg_len;
  } tx_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SEG_END,
    ST_STUFF_HI,
    ST_STUFF_LO,
    ST_SEND
  } tx_state_e;
endpackage

// File: rtl/tcsi_sum.sv
module tcsi_sum
  import tcsi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        add_i,
  input  logic        hi_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] csum_o
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] addend;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  assign addend = hi_i ? {{(SUM_W-16){1'b0}}, byte_i, 8'h00}
                       : {{(SUM_W-8){1'b0}}, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (add_i)   acc_q <= acc_q + addend;
  end

  // two folds suffice: acc stays far below 2^32 for a 2 KiB frame
  assign fold1  = {1'b0, acc_q[15:0]} + {1'b0, acc_q[SUM_W-1:16]};
  assign fold2  = fold1[15:0] + {15'd0, fold1[16]};
  assign csum_o = ~fold2;

  AST_SUM_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> csum_o == 16'hffff); // R2
endmodule

// File: rtl/tcsi_frame_ram.sv
module tcsi_frame_ram #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import tcsi_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  localparam int unsigned AW       = $clog2(BUF_BYTES),
  localparam int unsigned PTR_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_valid_i,
  input  logic [31:0]      desc_i,
  output logic             desc_ready_o,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  input  logic             tx_en_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  input  logic             out_ready_i,
  output logic             seg_done_o,
  output logic             frame_sent_o,
  output logic [PTR_W-1:0] frame_len_o
);
  tx_desc_t   desc;
  tx_state_e  state_q, state_d;
  logic       eop_q, cken_q;
  logic [5:0] start_q;
  logic [7:0] stuff_q;
  logic [12:0] rem_q;
  logic [PTR_W-1:0] pos_q, rd_q, sent_len_q;
  logic       sent_q;
  logic       desc_fire, in_fire, in_room, out_fire, in_window;
  logic       ram_we;
  logic [AW-1:0] ram_waddr;
  logic [7:0] ram_wdata;
  logic [15:0] csum;
  logic       go_send;
  logic       unused_desc;

  assign desc        = tx_desc_t'(desc_i);
  assign unused_desc = ^{desc.own, desc.rsvd};

  assign desc_ready_o = (state_q == ST_IDLE);
  assign in_ready_o   = (state_q == ST_LOAD);
  assign seg_done_o   = (state_q == ST_SEG_END);
  assign out_valid_o  = (state_q == ST_SEND);
  assign out_last_o   = out_valid_o && (rd_q == pos_q - 1'b1);
  assign frame_sent_o = sent_q;
  assign frame_len_o  = sent_len_q;

  assign desc_fire = desc_ready_o && desc_valid_i;
  assign in_fire   = in_ready_o && in_valid_i;
  assign out_fire  = out_valid_o && out_ready_i;
  assign in_room   = (pos_q < PTR_W'(BUF_BYTES));
  assign in_window = cken_q && (pos_q >= {{(PTR_W-6){1'b0}}, start_q});
  assign go_send   = tx_en_i && (pos_q != '0);

  tcsi_sum u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (desc_fire && desc.sop),
    .add_i  (in_fire && in_room && in_window),
    .hi_i   (pos_q[0] == start_q[0]),
    .byte_i (in_data_i),
    .csum_o (csum)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = pos_q[AW-1:0];
    ram_wdata = in_data_i;
    unique case (state_q)
      ST_LOAD:     ram_we = in_fire && in_room;
      ST_STUFF_HI: begin
        ram_we    = 1'b1;
        ram_waddr = AW'(stuff_q);
        ram_wdata = csum[15:8];
      end
      ST_STUFF_LO: begin
        ram_we    = 1'b1;
        ram_waddr = AW'(stuff_q) + 1'b1;
        ram_wdata = csum[7:0];
      end
      default: ;
    endcase
  end

  tcsi_frame_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (rd_q[AW-1:0]),
    .rdata_o (out_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (desc_fire) state_d = (desc.seg_len == '0) ? ST_SEG_END : ST_LOAD;
      ST_LOAD:     if (in_fire && rem_q == 13'd1) state_d = ST_SEG_END;
      ST_SEG_END: begin
        if (!eop_q)      state_d = ST_IDLE;
        else if (cken_q) state_d = ST_STUFF_HI;
        else             state_d = go_send ? ST_SEND : ST_IDLE;
      end
      ST_STUFF_HI: state_d = ST_STUFF_LO;
      ST_STUFF_LO: state_d = go_send ? ST_SEND : ST_IDLE;
      ST_SEND:     if (out_fire && out_last_o) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      eop_q      <= 1'b0;
      cken_q     <= 1'b0;
      start_q    <= '0;
      stuff_q    <= '0;
      rem_q      <= '0;
      pos_q      <= '0;
      rd_q       <= '0;
      sent_q     <= 1'b0;
      sent_len_q <= '0;
    end else begin
      state_q <= state_d;
      sent_q  <= 1'b0;
      if (desc_fire) begin
        eop_q  <= desc.eop;
        cken_q <= desc.csum_en;
        rem_q  <= desc.seg_len;
        if (desc.sop) begin
          pos_q   <= '0;
          start_q <= desc.start_ofs;
          stuff_q <= desc.stuff_ofs;
        end
      end
      if (in_fire) begin
        rem_q <= rem_q - 1'b1;
        if (in_room) pos_q <= pos_q + 1'b1;
      end
      if (state_d == ST_SEND && state_q != ST_SEND) rd_q <= '0;
      else if (out_fire) rd_q <= rd_q + 1'b1;
      if (out_fire && out_last_o) begin
        sent_q     <= 1'b1;
        sent_len_q <= pos_q;
      end
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= PTR_W'(BUF_BYTES)); // R6
  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_ready_o, in_ready_o, out_valid_o, seg_done_o})); // R11
  AST_SEG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_done_o |=> !seg_done_o); // R8
  AST_SENT_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_last_o |=> frame_sent_o && !out_valid_o); // R9
  AST_SENT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sent_o |=> !frame_sent_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R10
  AST_DROP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STUFF_LO) && !tx_en_i |=> !out_valid_o); // R7
endmodule

// File: tb/tx_csum_insert_tb.sv
module tx_csum_insert_tb;
  localparam int BUF = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic [31:0] desc = '0;
  logic        desc_ready;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        tx_en = 1'b1;
  logic        out_valid, out_last, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        seg_done, frame_sent;
  logic [11:0] frame_len;

  tx_csum_insert u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i(desc_valid), .desc_i(desc), .desc_ready_o(desc_ready),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .tx_en_i(tx_en),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready),
    .seg_done_o(seg_done), .frame_sent_o(frame_sent), .frame_len_o(frame_len)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int seg_cnt = 0, seg_double = 0, segs_sent = 0;
  logic prev_sd = 1'b0;
  int cycles = 0;

  logic [7:0] exp_buf [BUF];
  logic [7:0] got_buf [BUF];
  int exp_pos = 0;
  longint exp_sum = 0;
  int cap_start = 0, cap_stuff = 0;
  int fill_mode = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (seg_done) seg_cnt++;
      if (seg_done && prev_sd) seg_double++;
      prev_sd <= seg_done;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
    report();
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit sop, bit eop, bit ck, int stuff, int start, int len);
    mk = {1'($urandom_range(0, 1)), sop, eop, ck, 8'(stuff), 6'(start),
          1'($urandom_range(0, 1)), 13'(len)};
  endfunction

  function automatic logic [15:0] fold_inv(longint s);
    longint t = s;
    while (t >> 16) t = (t & 64'hffff) + (t >> 16);
    return ~16'(t);
  endfunction

  task automatic push_seg(input logic [31:0] st);
    int len = int'(st[12:0]);
    bit ck = st[28];
    desc = st;
    desc_valid = 1'b1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    segs_sent++;
    if (st[30]) begin
      exp_pos = 0; exp_sum = 0;
      cap_start = int'(st[19:14]); cap_stuff = int'(st[27:20]);
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = (fill_mode == 1) ? 8'hff : 8'($urandom);
      if (exp_pos < BUF) begin
        exp_buf[exp_pos] = b;
        if (ck && exp_pos >= cap_start)
          exp_sum += ((exp_pos - cap_start) % 2 == 0) ? longint'(b) << 8 : longint'(b);
        exp_pos++;
      end
      in_data = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    if (st[29] && ck) begin
      logic [15:0] c = fold_inv(exp_sum);
      exp_buf[cap_stuff] = c[15:8];
      exp_buf[cap_stuff + 1] = c[7:0];
    end
  endtask

  task automatic check_frame(input string tag, input bit en);
    int n = 0;
    int guard = 0;
    bit lastseen = 0;
    int bad = -1;
    if (en && exp_pos != 0) begin
      while (!lastseen && guard < 20000) begin
        @(negedge clk);
        guard++;
        out_ready = ($urandom_range(0, 2) != 0);
        if (out_valid && out_ready) begin
          if (n < BUF) got_buf[n] = out_data;
          n++;
          lastseen = out_last;
        end
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk(frame_sent == 1'b1, {"R9 sent strobe ", tag}, frame_sent, 1);
      chk(int'(frame_len) == exp_pos, {"R9 frame_len ", tag}, frame_len, exp_pos);
      chk(n == exp_pos, {"R10 beat count/last ", tag}, n, exp_pos);
      for (int i = 0; i < n && i < BUF; i++)
        if (bad < 0 && got_buf[i] !== exp_buf[i]) bad = i;
      chk(bad < 0, {"R3 R5 frame data ", tag}, (bad < 0) ? 0 : got_buf[bad],
          (bad < 0) ? 0 : exp_buf[bad]);
    end else begin
      bit seen = 0;
      repeat (16) begin
        @(negedge clk);
        if (out_valid || frame_sent) seen = 1;
      end
      chk(!seen, {"R7 discard ", tag}, seen, 0);
    end
    chk(seg_cnt == segs_sent && seg_double == 0, {"R8 seg_done ", tag}, seg_cnt, segs_sent);
  endtask

  initial begin
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    chk(desc_ready && !in_ready && !out_valid && !seg_done && !frame_sent, "R11 reset",
        {desc_ready, in_ready, out_valid, seg_done, frame_sent}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 single segment
    push_seg(mk(1, 1, 1, 24, 14, 40));
    check_frame("single", 1);

    // R3 window opens inside a later segment
    push_seg(mk(1, 0, 1, 40, 10, 5));
    push_seg(mk(0, 0, 1, 0, 0, 7));
    push_seg(mk(0, 1, 1, 0, 0, 30));
    check_frame("cross", 1);

    // R4 odd window length
    push_seg(mk(1, 1, 1, 2, 4, 21));
    check_frame("odd", 1);

    // R4 carry folding with all-ones data
    fill_mode = 1;
    push_seg(mk(1, 0, 1, 62, 0, 33));
    push_seg(mk(0, 1, 1, 0, 0, 31));
    fill_mode = 0;
    check_frame("carry", 1);

    // R5 frame end without checksum leaves data untouched
    push_seg(mk(1, 0, 0, 0, 0, 12));
    push_seg(mk(0, 1, 0, 3, 1, 9));
    check_frame("nock", 1);

    // R2 offsets on non-start descriptors are ignored
    push_seg(mk(1, 0, 1, 20, 8, 11));
    push_seg(mk(0, 1, 1, 2, 63, 25));
    check_frame("offs", 1);

    // R6 overflow truncation
    push_seg(mk(1, 0, 1, 10, 0, 1000));
    push_seg(mk(0, 0, 1, 0, 0, 1000));
    push_seg(mk(0, 1, 1, 0, 0, 500));
    check_frame("ovf", 1);

    // R7 discard, then recovery
    tx_en = 1'b0;
    push_seg(mk(1, 1, 1, 4, 2, 30));
    check_frame("drop", 0);
    tx_en = 1'b1;
    push_seg(mk(1, 0, 0, 0, 0, 6));
    push_seg(mk(0, 1, 0, 0, 0, 6));
    check_frame("after_drop", 1);

    // R8 zero-length segment
    push_seg(mk(1, 0, 1, 5, 3, 9));
    push_seg(mk(0, 0, 1, 0, 0, 0));
    push_seg(mk(0, 1, 1, 0, 0, 14));
    check_frame("zero_seg", 1);

    for (int f = 0; f < 25; f++) begin
      int ns = $urandom_range(1, 4);
      bit en = ($urandom_range(0, 4) != 0);
      tx_en = en;
      for (int s = 0; s < ns; s++)
        push_seg(mk(s == 0, s == ns - 1, 1'($urandom_range(0, 1)),
                    $urandom_range(0, 255), $urandom_range(0, 63), $urandom_range(0, 120)));
      check_frame($sformatf("rand%0d", f), en);
    end

    report();
  end
endmodule